// File: doc/BRIEF.md
# Alarm flag and interrupt controller

This block compares three external counter values against three host-programmed alarm values. The counters are a real-time seconds count, an interval timer and a cycle count. When a counter first becomes equal to its alarm, the block latches a sticky flag for that channel. It drives an interrupt line when the channel's active-low enable bit is cleared. The counters themselves live outside the block and arrive on input ports, so the block holds only the comparison, flag, enable and protection state.

A host reaches the block over a byte-wide register bus with an address, a read strobe and a write strobe. The status byte gathers the three flags and the three enables. Reading it returns the current flags and clears them in the same access. The control byte holds one sticky write-protect bit per channel, plus five general control bits that the host can store and read back. Each alarm value is spread over consecutive byte addresses, least significant byte first.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: When a counter input equals its alarm register on a rising clock edge, that channel's flag is 1 from that edge onward.
- R2: A flag is set only on the first edge of an equality. While the counter stays equal, a cleared flag is not set again. Leaving equality and then re-entering it sets the flag again.
- R3: The status byte is at address 0x200. Bit 0 is the real-time flag, bit 1 the interval flag and bit 2 the cycle flag. Bits 3, 4 and 5 are the matching interrupt enables. Bits 6 and 7 read as 0.
- R4: A status read returns the flag values from before the access and clears every flag at that edge. Host writes to status bits 0 to 2 have no effect on the flags.
- R5: If a match occurs on the same edge as a status read, that read returns the old value of the channel's flag, and the flag is 1 after the edge.
- R6: The irq output is 1 exactly when some flag is 1 and its enable bit is 0. irq changes on the same edge as the flags, so it falls on the edge of a clearing status read.
- R7: The enable bits are active low and store the value written to status bits 3 to 5. A flag whose enable bit is 1 does not raise irq.
- R8: The control byte is at address 0x201. Bits 0, 1 and 2 protect the real-time, interval and cycle channels. A write of 1 to a protect bit sets it, and only reset clears it. Bits 3 to 7 are plain storage that the host can read back.
- R9: While a channel's protect bit is 1, host writes to that channel's alarm bytes are ignored. The other channels remain writable.
- R10: Alarm registers are 32 bits wide and hold 4 bytes, least significant byte first. The real-time alarm is at 0x210 to 0x213, the interval alarm at 0x214 to 0x217 and the cycle alarm at 0x218 to 0x21B. All of them can be read back.
- R11: After reset, all flags are 0, all enable bits are 1, all protect and control bits are 0, all alarm registers are 0 and irq is 0.
- R12: Read data is registered. bus_rdata holds the addressed byte from the edge on which bus_rd is sampled. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rtc_count | input | 32 | Real-time seconds counter value |
| itv_count | input | 32 | Interval timer value |
| cyc_count | input | 32 | Cycle counter value |
| bus_addr | input | 12 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request, active high |

## Verification
The assertions take for granted that the counter inputs are synchronous to clk and that bus_rd and bus_wr are never high in the same cycle. They also assume that protect bits and alarm bytes are never written in a single access, because the two sit at different addresses. The bench changes counters and strobes only on the falling edge and issues one access at a time. It moves counters onto alarm values only where a scenario requires a match, and it sets reset-time counter values away from zero so that the zeroed alarms cannot fire.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int NUM_CH = 3;
  localparam int CH_RTC = 0;
  localparam int CH_ITV = 1;
  localparam int CH_CYC = 2;
  typedef logic [NUM_CH-1:0] ch_vec_t;
endpackage

// File: rtl/alarm_channel.sv
module alarm_channel #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 12,
  parameter int BASE   = 'h210
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_data,
  input  logic              wp,
  output logic [CNT_W-1:0]  alarm_q,
  output logic              hit
);
  localparam int NBYTES = CNT_W / 8;

  logic eq, eq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      alarm_q <= '0;
    end else if (wr_en && !wp) begin
      for (int b = 0; b < NBYTES; b++) begin
        if (addr == ADDR_W'(BASE + b)) alarm_q[b*8 +: 8] <= wr_data;
      end
    end
  end

  assign eq = (cnt == alarm_q);

  always_ff @(posedge clk) begin
    if (rst) eq_q <= 1'b0;
    else     eq_q <= eq;
  end

  assign hit = eq && !eq_q;

  // R2: a match produces a single-cycle event
  assert_hit_once_R2: assert property (@(posedge clk) disable iff (rst)
    hit |=> !hit);

  // R9: a protected alarm register does not change
  assert_locked_alarm_R9: assert property (@(posedge clk) disable iff (rst)
    wp |=> $stable(alarm_q));
endmodule

// File: rtl/alarm_status.sv
module alarm_status
  import alarm_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  ch_vec_t hit,
  input  logic    rd_stat,
  input  logic    wr_stat,
  input  ch_vec_t en_wdata,
  output ch_vec_t flags,
  output ch_vec_t en_n,
  output logic    irq
);
  ch_vec_t flags_d, en_d;

  always_comb begin
    flags_d = (rd_stat ? '0 : flags) | hit;
    en_d    = wr_stat ? en_wdata : en_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      en_n  <= '1;
      irq   <= 1'b0;
    end else begin
      flags <= flags_d;
      en_n  <= en_d;
      irq   <= |(flags_d & ~en_d);
    end
  end

  // R4, R5: a read leaves exactly the events that arrived with it
  assert_read_clears_R4: assert property (@(posedge clk) disable iff (rst)
    rd_stat |=> (flags == $past(hit)));

  // R6: irq follows flags gated by the active-low enables
  assert_irq_match_R6: assert property (@(posedge clk) disable iff (rst)
    irq == |(flags & ~en_n));

  // R1: an event always leaves its flag set
  assert_hit_sets_R1: assert property (@(posedge clk) disable iff (rst)
    (hit != '0) |=> ((flags & $past(hit)) == $past(hit)));
endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl
  import alarm_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int ADDR_W    = 12,
  parameter int STAT_ADDR = 'h200,
  parameter int CTRL_ADDR = 'h201,
  parameter int ALM_BASE  = 'h210
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  rtc_count,
  input  logic [CNT_W-1:0]  itv_count,
  input  logic [CNT_W-1:0]  cyc_count,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq
);
  localparam int ALM_BYTES = CNT_W / 8;

  logic [CNT_W-1:0] cnt_arr   [NUM_CH];
  logic [CNT_W-1:0] alarm_arr [NUM_CH];
  ch_vec_t hit, flags, en_n, wp_q;
  logic [4:0] misc_q;
  logic [7:0] rd_mux;
  logic sel_stat, sel_ctrl;

  assign cnt_arr[CH_RTC] = rtc_count;
  assign cnt_arr[CH_ITV] = itv_count;
  assign cnt_arr[CH_CYC] = cyc_count;

  assign sel_stat = (bus_addr == ADDR_W'(STAT_ADDR));
  assign sel_ctrl = (bus_addr == ADDR_W'(CTRL_ADDR));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    alarm_channel #(
      .CNT_W (CNT_W),
      .ADDR_W(ADDR_W),
      .BASE  (ALM_BASE + g * ALM_BYTES)
    ) u_ch (
      .clk    (clk),
      .rst    (rst),
      .cnt    (cnt_arr[g]),
      .wr_en  (bus_wr),
      .addr   (bus_addr),
      .wr_data(bus_wdata),
      .wp     (wp_q[g]),
      .alarm_q(alarm_arr[g]),
      .hit    (hit[g])
    );
  end

  alarm_status u_stat (
    .clk     (clk),
    .rst     (rst),
    .hit     (hit),
    .rd_stat (bus_rd && sel_stat),
    .wr_stat (bus_wr && sel_stat),
    .en_wdata(bus_wdata[5:3]),
    .flags   (flags),
    .en_n    (en_n),
    .irq     (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q   <= '0;
      misc_q <= '0;
    end else if (bus_wr && sel_ctrl) begin
      wp_q   <= wp_q | bus_wdata[2:0];
      misc_q <= bus_wdata[7:3];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (sel_stat) rd_mux = {2'b00, en_n, flags};
    if (sel_ctrl) rd_mux = {misc_q, wp_q};
    for (int c = 0; c < NUM_CH; c++) begin
      for (int b = 0; b < ALM_BYTES; b++) begin
        if (bus_addr == ADDR_W'(ALM_BASE + c * ALM_BYTES + b))
          rd_mux = alarm_arr[c][b*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R8: protect bits never fall outside reset
  assert_wp_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    ((wp_q & $past(wp_q)) == $past(wp_q)));

  // R12: read data only moves on a read strobe
  assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/tb_alarm_irq_ctrl.sv
`timescale 1ns/1ps
module tb_alarm_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] rtc_count, itv_count, cyc_count;
  logic [11:0] bus_addr;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic        irq;
  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  alarm_irq_ctrl dut (
    .clk(clk), .rst(rst),
    .rtc_count(rtc_count), .itv_count(itv_count), .cyc_count(cyc_count),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R11 irq after reset", irq, 0);
    rd(12'h200, d); chk("R11 R3 status after reset", d, 8'h38);
    rd(12'h201, d); chk("R11 control after reset", d, 8'h00);
    rd(12'h213, d); chk("R11 alarm after reset", d, 8'h00);
  endtask

  task automatic t_match();
    logic [7:0] d;
    wr(12'h210, 8'h55);
    rtc_count = 32'h54; @(negedge clk);
    rtc_count = 32'h55; @(negedge clk);
    chk("R7 disabled flag gives no irq", irq, 0);
    rd(12'h200, d); chk("R1 R3 rtc flag in bit 0", d, 8'h39);
    rd(12'h200, d); chk("R4 status read cleared flag", d, 8'h38);
    @(negedge clk);
    rd(12'h200, d); chk("R2 no refire while equal", d, 8'h38);
    rtc_count = 32'h56; @(negedge clk);
    rtc_count = 32'h55; @(negedge clk);
    rd(12'h200, d); chk("R2 refire after re-entry", d, 8'h39);
    rtc_count = 32'h1000; @(negedge clk);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    wr(12'h200, 8'h37);
    rd(12'h200, d); chk("R4 R7 flags read-only, enables stored", d, 8'h30);
    wr(12'h214, 8'h34); wr(12'h215, 8'h12);
    rd(12'h214, d); chk("R10 itv alarm byte 0", d, 8'h34);
    rd(12'h215, d); chk("R10 itv alarm byte 1", d, 8'h12);
    itv_count = 32'h1234; @(negedge clk);
    chk("R7 disabled itv flag gives no irq", irq, 0);
    rtc_count = 32'h55; @(negedge clk);
    chk("R6 irq raised by enabled rtc flag", irq, 1);
    rd(12'h200, d); chk("R1 R10 both flags set", d, 8'h33);
    chk("R6 irq falls on clearing read", irq, 0);
    rtc_count = 32'h1000; itv_count = 32'h2000; @(negedge clk);
  endtask

  task automatic t_coincide();
    logic [7:0] d;
    wr(12'h218, 8'hEF); wr(12'h219, 8'hBE);
    cyc_count = 32'hBEEF;
    rd(12'h200, d); chk("R5 coincident read sees old flag", d, 8'h30);
    rd(12'h200, d); chk("R5 coincident flag kept", d, 8'h34);
    cyc_count = 32'h3000; @(negedge clk);
  endtask

  task automatic t_protect();
    logic [7:0] d;
    wr(12'h201, 8'h09);
    rd(12'h201, d); chk("R8 control readback", d, 8'h09);
    wr(12'h210, 8'hAA);
    rd(12'h210, d); chk("R9 protected alarm write ignored", d, 8'h55);
    wr(12'h216, 8'h77);
    rd(12'h216, d); chk("R9 other channel writable", d, 8'h77);
    wr(12'h201, 8'h00);
    rd(12'h201, d); chk("R8 protect bit sticky", d, 8'h01);
    rtc_count = 32'hAA; @(negedge clk);
    rd(12'h200, d); chk("R9 ignored write made no alarm", d, 8'h30);
    rtc_count = 32'h1000;
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    rd(12'h300, d); chk("R12 unmapped reads zero", d, 8'h00);
    bus_addr = 12'h201; @(negedge clk);
    chk("R12 rdata held without strobe", bus_rdata, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
    rtc_count = 32'h1000; itv_count = 32'h2000; cyc_count = 32'h3000;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_match();
    t_irq();
    t_coincide();
    t_protect();
    t_unmapped();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule